// File: doc/BRIEF.md
# Banked Effective Address Generator

This block forms the 24-bit operand address for two addressing modes of a 16-bit controller whose upper address byte comes from a bank register. It then fetches the 16-bit operand through a byte-wide memory port. In program-relative mode the 16-bit offset is the address of the current instruction, plus a fixed bias of 4, plus a signed 16-bit displacement. The bank byte comes from the program bank register. In base-plus-index mode the offset is one of two base registers plus an index register, and the bank byte comes from the data bank register.

A request is taken only while the block is idle, and every operand is sampled in that cycle. The block then makes two byte reads, each one finished by a valid/ready handshake. It assembles the word low byte first and raises a one-cycle completion pulse that carries both the word and the effective address. The offset arithmetic wraps within 16 bits and never changes the bank byte.

Top module: `bank_ea_gen`

## Requirements
- R1: When `req_mode` = 0 (program-relative), the offset (bits 15:0 of the address) is `inst_addr + 4 + disp` modulo 2^16. The bias is always 4, whatever the instruction length.
- R2: When `req_mode` = 0, address bits 23:16 equal `pc_bank`.
- R3: When `req_mode` = 1 (base-plus-index), the offset is `base + rw7` modulo 2^16. `base` is `rw0` when `req_base_sel` = 0 and `rw1` when `req_base_sel` = 1.
- R4: When `req_mode` = 1, address bits 23:16 equal `data_bank`.
- R5: A carry out of bit 15 of any offset sum is dropped. The bank byte is never altered by it.
- R6: Each request makes exactly two memory reads. The first is at the effective address. The second is at the same bank with offset+1, which wraps from FFFF to 0000.
- R7: `word_out` bits 7:0 hold the byte read at the effective address, and bits 15:8 hold the byte read at the second address.
- R8: `done` is high for exactly one cycle. That cycle is the one after the second read handshake. In it, `word_out` and `ea_out` hold the result of that request.
- R9: `req_ready` is high only while no fetch is in progress. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Later changes to the request inputs do not affect that request's result.
- R10: After reset, `req_ready` = 1, `mem_valid` = 0 and `done` = 0.
- R11: While `mem_valid` is high and `mem_ready` is low, `mem_valid` stays high and `mem_addr` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_mode | input | 1 | 0 program-relative, 1 base-plus-index |
| req_base_sel | input | 1 | Base register choice: 0 rw0, 1 rw1 |
| inst_addr | input | 16 | Address of the current instruction |
| disp | input | 16 | Signed displacement |
| pc_bank | input | 8 | Program bank register |
| data_bank | input | 8 | Data bank register |
| rw0 | input | 16 | Base register 0 |
| rw1 | input | 16 | Base register 1 |
| rw7 | input | 16 | Index register |
| mem_valid | output | 1 | Byte read request |
| mem_ready | input | 1 | Memory completes the read this cycle |
| mem_addr | output | 24 | Byte read address |
| mem_rdata | input | 8 | Byte read data, valid with mem_ready |
| done | output | 1 | Result pulse |
| ea_out | output | 24 | Effective address of the finished request |
| word_out | output | 16 | Assembled operand word |

## Verification
The bench uses a byte pattern that depends on the address, so a wrongly captured bank byte or offset shows up twice: at `mem_addr` on the first handshake after acceptance, and later in `word_out`. A wrong byte-index counter or bad lane steering shows as a second read at a wrong address, or as swapped bytes in the word, in the `done` cycle at most two handshakes later. A busy flag that is stuck shows as a lost or duplicated `done` pulse, or as `req_ready` high alongside `mem_valid` at the next sample.

// File: rtl/ea_pkg.sv
package ea_pkg;

   typedef enum logic {
      EA_PC_REL   = 1'b0,
      EA_BASE_IDX = 1'b1
   } ea_mode_e;

   typedef enum logic {
      FS_IDLE = 1'b0,
      FS_BUSY = 1'b1
   } fetch_state_e;

endpackage

// File: rtl/ea_offset_calc.sv
module ea_offset_calc
   import ea_pkg::*;
#(
   parameter int OFS_W   = 16,
   parameter int BANK_W  = 8,
   parameter int PC_BIAS = 4
) (
   input  ea_mode_e            mode,
   input  logic                base_sel,
   input  logic [OFS_W-1:0]    inst_addr,
   input  logic [OFS_W-1:0]    disp,
   input  logic [BANK_W-1:0]   pc_bank,
   input  logic [BANK_W-1:0]   data_bank,
   input  logic [OFS_W-1:0]    rw0,
   input  logic [OFS_W-1:0]    rw1,
   input  logic [OFS_W-1:0]    rw7,
   output logic [BANK_W+OFS_W-1:0] ea
);
   localparam logic [OFS_W-1:0] BIAS = OFS_W'(PC_BIAS);

   generate
      if (PC_BIAS < 0) begin : g_bad_bias
         $error("PC_BIAS must not be negative");
      end
      if (OFS_W < 2 || BANK_W < 1) begin : g_bad_width
         $error("offset or bank width too small");
      end
   endgenerate

   logic [OFS_W-1:0] rel_ofs;
   logic [OFS_W-1:0] idx_ofs;
   logic [OFS_W-1:0] base_val;

   // sums are kept at OFS_W bits so a carry never reaches the bank byte
   always_comb begin
      base_val = base_sel ? rw1 : rw0;
      rel_ofs  = inst_addr + BIAS + disp;
      idx_ofs  = base_val + rw7;
      if (mode == EA_BASE_IDX) ea = {data_bank, idx_ofs};
      else                     ea = {pc_bank, rel_ofs};
   end

endmodule

// File: rtl/ea_word_fetch.sv
module ea_word_fetch
   import ea_pkg::*;
#(
   parameter int OFS_W     = 16,
   parameter int BANK_W    = 8,
   parameter int BYTE_W    = 8,
   parameter int WORD_W    = 16,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [BANK_W+OFS_W-1:0] start_ea,
   output logic                    idle,
   output logic                    mem_valid,
   input  logic                    mem_ready,
   output logic [BANK_W+OFS_W-1:0] mem_addr,
   input  logic [BYTE_W-1:0]       mem_rdata,
   output logic                    done,
   output logic [BANK_W+OFS_W-1:0] ea_out,
   output logic [WORD_W-1:0]       word_out
);
   localparam int ADDR_W     = BANK_W + OFS_W;
   localparam int WORD_BYTES = WORD_W / BYTE_W;
   localparam int IDX_W      = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_BYTES - 1);

   generate
      if (WORD_W % BYTE_W != 0) begin : g_bad_word
         $error("WORD_W must be a multiple of BYTE_W");
      end
      if (WORD_BYTES < 2) begin : g_bad_bytes
         $error("word must span at least two bytes");
      end
   endgenerate

   fetch_state_e              state_q;
   logic [IDX_W-1:0]          idx_q;
   logic [ADDR_W-1:0]         ea_q;
   logic [BYTE_W-1:0]         lane_q [WORD_BYTES];
   logic                      done_q;
   logic                      hs;
   logic [OFS_W-1:0]          step_ofs;

   assign idle      = (state_q == FS_IDLE);
   assign mem_valid = (state_q == FS_BUSY);
   assign hs        = mem_valid && mem_ready;
   // byte step wraps inside the offset; bank field is passed through unchanged
   assign step_ofs  = ea_q[OFS_W-1:0] + OFS_W'(idx_q);
   assign mem_addr  = {ea_q[ADDR_W-1:OFS_W], step_ofs};
   assign done      = done_q;
   assign ea_out    = ea_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= FS_IDLE;
         idx_q   <= '0;
         ea_q    <= '0;
         done_q  <= 1'b0;
         for (int i = 0; i < WORD_BYTES; i++) lane_q[i] <= '0;
      end else begin
         done_q <= 1'b0;
         if (state_q == FS_IDLE) begin
            if (start) begin
               ea_q    <= start_ea;
               idx_q   <= '0;
               state_q <= FS_BUSY;
            end
         end else if (hs) begin
            lane_q[idx_q] <= mem_rdata;
            if (idx_q == LAST_IDX) begin
               state_q <= FS_IDLE;
               done_q  <= 1'b1;
            end else begin
               idx_q <= idx_q + 1'b1;
            end
         end
      end
   end

   genvar gi;
   generate
      for (gi = 0; gi < WORD_BYTES; gi++) begin : g_lane
         if (LOW_FIRST) begin : g_le
            assign word_out[gi*BYTE_W +: BYTE_W] = lane_q[gi];
         end else begin : g_be
            assign word_out[gi*BYTE_W +: BYTE_W] = lane_q[WORD_BYTES-1-gi];
         end
      end
   endgenerate

   // R11: a stalled read keeps its address
   assert_addr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));

   // R6: a handshake that is not the last moves to offset+1 in the same bank
   assert_step_same_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hs && idx_q != LAST_IDX) |=>
         (mem_valid && mem_addr[ADDR_W-1:OFS_W] == $past(mem_addr[ADDR_W-1:OFS_W])
          && mem_addr[OFS_W-1:0] == $past(mem_addr[OFS_W-1:0]) + 1'b1));

   // R8: completion lasts one cycle and follows a handshake
   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_after_hs_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(hs));

   // R9: never ready while a read is outstanding
   assert_busy_not_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> !idle);

endmodule

// File: rtl/bank_ea_gen.sv
module bank_ea_gen
   import ea_pkg::*;
#(
   parameter int OFS_W     = 16,
   parameter int BANK_W    = 8,
   parameter int BYTE_W    = 8,
   parameter int WORD_W    = 16,
   parameter int PC_BIAS   = 4,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic                    req_mode,
   input  logic                    req_base_sel,
   input  logic [OFS_W-1:0]        inst_addr,
   input  logic [OFS_W-1:0]        disp,
   input  logic [BANK_W-1:0]       pc_bank,
   input  logic [BANK_W-1:0]       data_bank,
   input  logic [OFS_W-1:0]        rw0,
   input  logic [OFS_W-1:0]        rw1,
   input  logic [OFS_W-1:0]        rw7,
   output logic                    mem_valid,
   input  logic                    mem_ready,
   output logic [BANK_W+OFS_W-1:0] mem_addr,
   input  logic [BYTE_W-1:0]       mem_rdata,
   output logic                    done,
   output logic [BANK_W+OFS_W-1:0] ea_out,
   output logic [WORD_W-1:0]       word_out
);
   localparam int ADDR_W = BANK_W + OFS_W;

   logic [ADDR_W-1:0] calc_ea;
   logic              idle;
   logic              accept;

   assign req_ready = idle;
   assign accept    = req_valid && idle;

   ea_offset_calc #(
      .OFS_W   (OFS_W),
      .BANK_W  (BANK_W),
      .PC_BIAS (PC_BIAS)
   ) u_calc (
      .mode      (ea_mode_e'(req_mode)),
      .base_sel  (req_base_sel),
      .inst_addr (inst_addr),
      .disp      (disp),
      .pc_bank   (pc_bank),
      .data_bank (data_bank),
      .rw0       (rw0),
      .rw1       (rw1),
      .rw7       (rw7),
      .ea        (calc_ea)
   );

   ea_word_fetch #(
      .OFS_W     (OFS_W),
      .BANK_W    (BANK_W),
      .BYTE_W    (BYTE_W),
      .WORD_W    (WORD_W),
      .LOW_FIRST (LOW_FIRST)
   ) u_fetch (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (accept),
      .start_ea  (calc_ea),
      .idle      (idle),
      .mem_valid (mem_valid),
      .mem_ready (mem_ready),
      .mem_addr  (mem_addr),
      .mem_rdata (mem_rdata),
      .done      (done),
      .ea_out    (ea_out),
      .word_out  (word_out)
   );

   // R2 / R4: captured bank byte follows the mode's bank register
   assert_bank_src_R2_R4: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (ea_out[ADDR_W-1:OFS_W] ==
                  $past(req_mode ? data_bank : pc_bank)));

   // R6: first read of a request goes to the captured address
   assert_first_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (mem_valid && mem_addr == ea_out));

endmodule

// File: tb/bank_ea_gen_bench.sv
module bank_ea_gen_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_mode = 1'b0;
   logic        req_base_sel = 1'b0;
   logic [15:0] inst_addr = '0, disp = '0, rw0 = '0, rw1 = '0, rw7 = '0;
   logic [7:0]  pc_bank = '0, data_bank = '0;
   logic        mem_valid;
   logic        mem_ready = 1'b0;
   logic [23:0] mem_addr;
   logic [7:0]  mem_rdata = '0;
   logic        done;
   logic [23:0] ea_out;
   logic [15:0] word_out;

   int n_checks = 0;
   int n_fail   = 0;
   int n_issued = 0;
   int n_done   = 0;

   logic [23:0] q_ea[$];
   logic [15:0] q_word[$];
   logic [23:0] q_addr[$];
   string       q_tag[$];

   always #5 clk = ~clk;

   bank_ea_gen u_bank_ea_gen (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_mode(req_mode), .req_base_sel(req_base_sel), .inst_addr(inst_addr),
      .disp(disp), .pc_bank(pc_bank), .data_bank(data_bank), .rw0(rw0),
      .rw1(rw1), .rw7(rw7), .mem_valid(mem_valid), .mem_ready(mem_ready),
      .mem_addr(mem_addr), .mem_rdata(mem_rdata), .done(done),
      .ea_out(ea_out), .word_out(word_out)
   );

   function automatic logic [7:0] mbyte(input logic [23:0] a);
      return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'h5A;
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic issue(input bit m, input bit sel, input logic [15:0] ia,
                        input logic [15:0] d, input logic [7:0] pcb,
                        input logic [7:0] dtb, input logic [15:0] r0,
                        input logic [15:0] r1, input logic [15:0] r7);
      logic [15:0] ofs;
      logic [7:0]  bk;
      logic [23:0] a0, a1;
      @(negedge clk);
      req_mode = m; req_base_sel = sel; inst_addr = ia; disp = d;
      pc_bank = pcb; data_bank = dtb; rw0 = r0; rw1 = r1; rw7 = r7;
      req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      // expected values from R1..R7
      ofs = m ? ((sel ? r1 : r0) + r7) : (ia + 16'd4 + d);
      bk  = m ? dtb : pcb;
      a0  = {bk, ofs};
      a1  = {bk, ofs + 16'd1};
      q_ea.push_back(a0);
      q_word.push_back({mbyte(a1), mbyte(a0)});
      q_addr.push_back(a0);
      q_addr.push_back(a1);
      q_tag.push_back(m ? "R3 R4 R5" : "R1 R2 R5");
      n_issued++;
      @(negedge clk);
      req_valid = 1'b0;
      // R9: scramble the request inputs after acceptance
      inst_addr = ~ia; disp = ~d; pc_bank = ~pcb; data_bank = ~dtb;
      rw0 = ~r0; rw1 = ~r1; rw7 = ~r7; req_mode = ~m; req_base_sel = ~sel;
   endtask

   // memory model and monitor, one process at the falling edge
   logic [7:0]  lfsr = 8'hA5;
   logic        prev_stall = 1'b0;
   logic [23:0] prev_addr = '0;
   logic        prev_done = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_done) check(!done, "R8 pulse width", {31'b0, done}, 32'd0);
         if (done) begin
            n_done++;
            if (q_ea.size() == 0) begin
               check(1'b0, "R8 unexpected done", 32'd1, 32'd0);
            end else begin
               logic [23:0] e_ea;
               logic [15:0] e_w;
               string       tg;
               e_ea = q_ea.pop_front();
               e_w  = q_word.pop_front();
               tg   = q_tag.pop_front();
               check(ea_out == e_ea, {tg, " ea_out"}, {8'h0, ea_out}, {8'h0, e_ea});
               check(word_out == e_w, "R7 word_out", {16'h0, word_out}, {16'h0, e_w});
            end
         end
         prev_done = done;
         check(req_ready == !mem_valid, "R9 ready vs busy",
               {31'b0, req_ready}, {31'b0, !mem_valid});
         if (prev_stall)
            check(mem_valid && mem_addr == prev_addr, "R11 held address",
                  {8'h0, mem_addr}, {8'h0, prev_addr});
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         mem_ready = mem_valid && (lfsr[0] || lfsr[1]);
         mem_rdata = mbyte(mem_addr);
         if (mem_valid && mem_ready) begin
            if (q_addr.size() == 0) begin
               check(1'b0, "R6 unexpected read", {8'h0, mem_addr}, 32'd0);
            end else begin
               logic [23:0] e_a;
               e_a = q_addr.pop_front();
               check(mem_addr == e_a, "R6 read address", {8'h0, mem_addr}, {8'h0, e_a});
            end
         end
         prev_stall = mem_valid && !mem_ready;
         prev_addr  = mem_addr;
      end else begin
         mem_ready = 1'b0;
      end
   end

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin : main
      logic [31:0] seed;
      seed = 32'h1234_5678;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R10: state after reset
      check(req_ready == 1'b1, "R10 req_ready", {31'b0, req_ready}, 32'd1);
      check(mem_valid == 1'b0, "R10 mem_valid", {31'b0, mem_valid}, 32'd0);
      check(done == 1'b0, "R10 done", {31'b0, done}, 32'd0);
      rst_n = 1'b1;

      // R1 R2: C5:4556 + 4 + 0020 -> C5:457A
      issue(1'b0, 1'b0, 16'h4556, 16'h0020, 8'hC5, 8'h11, 16'h0, 16'h0, 16'h0);
      wait (n_done == 1);
      @(negedge clk);
      check(ea_out == 24'hC5457A, "R1 R2 literal example", {8'h0, ea_out}, 32'hC5457A);
      // R3 R4: 78 / D30F + 0101 -> 78:D410
      issue(1'b1, 1'b1, 16'h0, 16'h0, 8'h22, 8'h78, 16'h1111, 16'hD30F, 16'h0101);
      wait (n_done == 2);
      @(negedge clk);
      check(ea_out == 24'h78D410, "R3 R4 literal example", {8'h0, ea_out}, 32'h78D410);
      // R5: program-relative wrap past FFFF
      issue(1'b0, 1'b0, 16'hFFFE, 16'h0001, 8'h3A, 8'h00, 16'h0, 16'h0, 16'h0);
      // R1: negative displacement
      issue(1'b0, 1'b1, 16'h0010, 16'hFFF0, 8'h07, 8'h99, 16'h0, 16'h0, 16'h0);
      // R3 R5: rw0 selected, index sum wraps
      issue(1'b1, 1'b0, 16'h0, 16'h0, 8'h44, 8'hF0, 16'hFFFF, 16'h8000, 16'h0002);
      // R6: offset FFFF, second byte at bank:0000
      issue(1'b0, 1'b0, 16'hFFF0, 16'h000B, 8'h5C, 8'h00, 16'h0, 16'h0, 16'h0);
      issue(1'b1, 1'b1, 16'h0, 16'h0, 8'h00, 8'hE1, 16'h0, 16'hFFFE, 16'h0001);
      // back-to-back mixed traffic
      for (int k = 0; k < 40; k++) begin
         logic [31:0] s1, s2;
         seed = seed * 32'd1664525 + 32'd1013904223; s1 = seed;
         seed = seed * 32'd1664525 + 32'd1013904223; s2 = seed;
         issue(s1[31], s1[30], s1[15:0], s2[15:0], s1[23:16], s2[23:16],
               s2[31:16], s1[29:14], s1[27:12] ^ s2[15:0]);
      end
      wait (n_done == n_issued);
      repeat (4) @(negedge clk);
      // R8: one done per request, nothing left over
      check(n_done == n_issued, "R8 done count", n_done, n_issued);
      check(q_addr.size() == 0, "R6 leftover reads", q_addr.size(), 32'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule